// File: doc/BRIEF.md
# Protected Memory Checksum Engine

This block produces a 16-bit verification checksum over an image of 12-bit words. A programming or test controller supplies a configuration word and four identification words, then pulses `start`. The engine walks the image through a synchronous read port, one address per cycle. It adds every word it reads to a seed term and raises `done` with the result.

Bit 4 of the configuration word selects the mode. When the bit is 1, protection is off and the scan covers the whole user image. When the bit is 0, protection is on and only the short always-readable head of the image is summed. In that case the four ID nibbles, packed into one 16-bit value, are added in. In both modes the low byte of the configuration word joins the sum. All arithmetic is modulo 2^16.

Top module: `cks_engine`

## Requirements
- R1: All additions wrap modulo 2^16: only the low 16 bits of the running sum are kept and carries out of bit 15 are lost.
- R2: With protection off, the result is the sum of the words at addresses 0x000 through 0x3FE plus (configuration word AND 0x0FF).
- R3: With protection on, the result is the sum of the words at addresses 0x000 through 0x03F, plus (configuration word AND 0x0FF), plus the packed ID term.
- R4: The packed ID term is built from the low nibble of each ID word. ID0 occupies `id_words[11:0]`, ID1 `[23:12]`, ID2 `[35:24]` and ID3 `[47:36]`. ID0 goes to result bits 15:12 and ID3 to bits 3:0, and the upper 8 bits of each ID word have no effect.
- R5: Protection is on exactly when bit 4 of the configuration word is 0.
- R6: During a scan, `rd_en` is high for one cycle per address. `rd_addr` starts at 0 and rises by one each cycle up to the last address of the selected range and no further. The word for an address is taken from `rd_data` one cycle after that address is presented.
- R7: After reset, `done` and `rd_en` are low and `checksum` is 0.
- R8: `done` is low from the cycle after an accepted `start` until the result is ready. It then stays high and `checksum` stays constant until the next accepted `start`.
- R9: The configuration and ID words are captured when `start` is accepted. A `start` pulse, or a change on `cfg_word` or `id_words`, while a scan is running has no effect on that scan's result or on the address sequence.
- R10: For a blank image (every word 0xFFF), a configuration word of 0xFFF gives 0xED00. A configuration word of 0xFEF with ID nibbles E, D, 0, 0 gives 0xEDAF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; accepted only when no scan is running |
| cfg_word | input | 12 | Configuration word; bit 4 low means protected |
| id_words | input | 48 | Four ID words, ID0 in the low 12 bits |
| rd_en | output | 1 | Read request to the image memory |
| rd_addr | output | 11 | Word address of the read |
| rd_data | input | 12 | Read data, valid the cycle after the request |
| done | output | 1 | Result is valid |
| checksum | output | 16 | 16-bit checksum |

## Verification
The assertions assume that the memory answers every request on the next cycle with no stall. They also assume that `start` is a single-cycle pulse driven from a registered source. The bench models the memory as a one-cycle registered read of a computed pattern, so the first assumption always holds. It raises `start` for exactly one cycle per scan, including the extra pulse sent during a running scan to exercise R9.

// File: rtl/cks_pkg.sv
package cks_pkg;

  localparam int WORD_W = 12;
  localparam int SUM_W  = 16;
  localparam int N_IDS  = 4;
  localparam int NIB_W  = SUM_W / N_IDS;

  // R5: protection bit is active low
  function automatic logic is_protected(input logic [WORD_W-1:0] cfg, input int prot_bit);
    return (cfg[prot_bit] == 1'b0);
  endfunction

  // R4: ID0 lands in the top nibble
  function automatic logic [SUM_W-1:0] pack_ids(input logic [N_IDS*WORD_W-1:0] ids);
    logic [SUM_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_IDS; i++)
      r[SUM_W-1-i*NIB_W -: NIB_W] = ids[i*WORD_W +: NIB_W];
    return r;
  endfunction

  // R2 R3: starting value of the accumulator
  function automatic logic [SUM_W-1:0] seed_term(input logic [WORD_W-1:0] cfg,
                                                 input logic [N_IDS*WORD_W-1:0] ids,
                                                 input logic [WORD_W-1:0] cfg_mask,
                                                 input int prot_bit);
    logic [SUM_W-1:0] s;
    s = SUM_W'(cfg & cfg_mask);
    if (is_protected(cfg, prot_bit)) s = s + pack_ids(ids);
    return s;
  endfunction

endpackage

// File: rtl/cks_addr_seq.sv
module cks_addr_seq #(
  parameter int ADDR_W    = 11,
  parameter int FULL_LAST = 'h3FE,
  parameter int PROT_LAST = 'h03F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              prot,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_last
);
  localparam logic [ADDR_W-1:0] FULL_L = ADDR_W'(FULL_LAST);
  localparam logic [ADDR_W-1:0] PROT_L = ADDR_W'(PROT_LAST);

  logic              busy;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      lim  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      addr <= '0;
      lim  <= prot ? PROT_L : FULL_L;
    end else if (busy) begin
      if (addr == lim) busy <= 1'b0;
      else             addr <= addr + 1'b1;
    end
  end

  assign rd_en   = busy;
  assign rd_addr = addr;
  assign rd_last = busy && (addr == lim);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_last && !launch) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1)); // R6
  AST_ADDR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= FULL_L)); // R6
  AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && !launch) |=> !rd_en); // R6
endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
  parameter int SUM_W  = 16,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [SUM_W-1:0]  seed,
  input  logic              vld,
  input  logic              last,
  input  logic [WORD_W-1:0] data,
  output logic [SUM_W-1:0]  sum,
  output logic              done
);
  logic [SUM_W-1:0] acc;
  logic             fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      fin <= 1'b0;
    end else if (launch) begin
      acc <= seed;
      fin <= 1'b0;
    end else if (vld) begin
      acc <= acc + SUM_W'(data);   // R1: carry out of the top bit is dropped
      if (last) fin <= 1'b1;
    end
  end

  assign sum  = acc;
  assign done = fin;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> (done && $stable(sum))); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(vld && last)); // R8
  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !done); // R8
endmodule

// File: rtl/cks_engine.sv
module cks_engine #(
  parameter int ADDR_W    = 11,
  parameter int FULL_LAST = 'h3FE,
  parameter int PROT_LAST = 'h03F,
  parameter int CFG_MASK  = 'h0FF,
  parameter int PROT_BIT  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [11:0]         cfg_word,
  input  logic [47:0]         id_words,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [11:0]         rd_data,
  output logic                done,
  output logic [15:0]         checksum
);
  import cks_pkg::*;

  localparam logic [WORD_W-1:0] MASK_W = WORD_W'(CFG_MASK);
  localparam logic [ADDR_W-1:0] PROT_L = ADDR_W'(PROT_LAST);

  logic             vld_q, last_q, prot_q;
  logic             rd_last;
  logic             scan_busy;
  logic             launch;
  logic             prot_now;
  logic [SUM_W-1:0] seed;

  assign scan_busy = rd_en | vld_q;
  assign launch    = start & ~scan_busy;              // R9
  assign prot_now  = is_protected(cfg_word, PROT_BIT);
  assign seed      = seed_term(cfg_word, id_words, MASK_W, PROT_BIT);

  cks_addr_seq #(.ADDR_W(ADDR_W), .FULL_LAST(FULL_LAST), .PROT_LAST(PROT_LAST)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .prot(prot_now),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last)
  );

  // one-cycle read latency: data for the address of cycle n arrives in n+1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      vld_q  <= rd_en;
      last_q <= rd_last;
      if (launch) prot_q <= prot_now;
    end
  end

  cks_accum #(.SUM_W(SUM_W), .WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .launch(launch), .seed(seed),
    .vld(vld_q), .last(last_q), .data(rd_data),
    .sum(checksum), .done(done)
  );

  AST_PROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && prot_q) |-> (rd_addr <= PROT_L)); // R3
  AST_NO_DONE_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !done); // R8
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (rd_en && rd_addr == '0)); // R6
endmodule

// File: tb/cks_engine_tb.sv
module cks_engine_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [11:0] cfg_word = '0;
  logic [47:0] id_words = '0;
  logic        rd_en;
  logic [10:0] rd_addr;
  logic [11:0] rd_data = '0;
  logic        done;
  logic [15:0] checksum;

  int errors = 0;
  int checks = 0;
  int mode = 0;
  int reads = 0;
  int seq_bad = 0;
  int next_addr = 0;

  always #2.5 clk = ~clk;

  cks_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .id_words(id_words),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .checksum(checksum)
  );

  function automatic logic [11:0] word_at(int m, int a);
    case (m)
      0: return 12'hFFF;
      1: return 12'(a * 37 + 5);
      2: return 12'(a) ^ 12'hA5A;
      default: return 12'h000;
    endcase
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= word_at(mode, int'(rd_addr));

  // address monitor, sampled away from the edge
  always @(negedge clk) if (rst_n && rd_en) begin
    if (int'(rd_addr) != next_addr) seq_bad++;
    next_addr = int'(rd_addr) + 1;
    reads++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_sum(int m, logic [11:0] cfg, logic [47:0] ids);
    logic [15:0] s;
    int last;
    bit prot;
    prot = (cfg[4] == 1'b0);
    last = prot ? 'h03F : 'h3FE;
    s = 16'(cfg & 12'h0FF);
    for (int a = 0; a <= last; a++) s = s + {4'h0, word_at(m, a)};
    if (prot) s = s + {ids[3:0], ids[15:12], ids[27:24], ids[39:36]};
    return s;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  task automatic run(string req, int m, logic [11:0] cfg, logic [47:0] ids, int exp_reads);
    logic [15:0] e;
    mode = m; cfg_word = cfg; id_words = ids;
    reads = 0; seq_bad = 0; next_addr = 0;
    e = expect_sum(m, cfg, ids);
    pulse_start();
    check("R8 done low during scan", 32'(done), 32'h0);
    wait_done();
    check(req, 32'(checksum), 32'(e));
    check("R6 read count", 32'(reads), 32'(exp_reads));
    check("R6 address sequence", 32'(seq_bad), 32'h0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R7 done after reset", 32'(done), 32'h0);
    check("R7 rd_en after reset", 32'(rd_en), 32'h0);
    check("R7 checksum after reset", 32'(checksum), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R10 blank image, both modes (also exercises R1 wrap)
    run("R10 blank unprotected", 0, 12'hFFF, 48'hFFF_FFF_FFF_FFF, 'h3FF);
    check("R10 blank unprotected value", 32'(checksum), 32'hED00);
    run("R10 blank protected", 0, 12'hFEF, 48'hF00_F00_FFD_FFE, 'h40);
    check("R10 blank protected value", 32'(checksum), 32'hEDAF);

    // R2 R5: other patterns with bit 4 set
    run("R2 pattern1 unprotected", 1, 12'h7D3, 48'h123_456_789_ABC, 'h3FF);
    run("R2 pattern2 unprotected", 2, 12'h010, 48'h0, 'h3FF);
    // R3 R5: bit 4 clear
    run("R3 pattern1 protected", 1, 12'hFE5, 48'hAB4_CD3_EF2_011, 'h40);
    run("R3 pattern2 protected", 2, 12'h0C0, 48'h5A9_A58_3C7_C36, 'h40);

    // R4: zero image, zero masked config: result is packed ID alone
    run("R4 packing", 3, 12'hF00, 48'hFF4_AB3_CD2_EF1, 'h40);
    check("R4 packed value", 32'(checksum), 32'h1234);
    for (int k = 0; k < 16; k++) begin
      logic [3:0] n;
      n = 4'(k);
      run("R4 nibble sweep", 3, 12'h000, {8'h5A, n, 8'hC3, ~n, 8'h00, n, 8'hFF, ~n}, 'h40);
      check("R4 nibble order", 32'(checksum), 32'({~n, n, ~n, n}));
    end

    // R8 hold after done
    held = checksum;
    repeat (20) @(negedge clk);
    check("R8 done held", 32'(done), 32'h1);
    check("R8 checksum held", 32'(checksum), 32'(held));

    // R9: extra start and input change mid scan are ignored
    mode = 1; cfg_word = 12'hFFF; id_words = 48'h0;
    reads = 0; seq_bad = 0; next_addr = 0;
    pulse_start();
    repeat (10) @(negedge clk);
    cfg_word = 12'h0EF; id_words = 48'hFFF_FFF_FFF_FFF;
    pulse_start();
    wait_done();
    check("R9 result unchanged", 32'(checksum), 32'(expect_sum(1, 12'hFFF, 48'h0)));
    check("R9 address sequence", 32'(seq_bad), 32'h0);
    check("R9 read count", 32'(reads), 32'h3FF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule